// File: doc/BRIEF.md
# Mask and Status Interrupt Collector

This block gathers up to 32 asynchronous interrupt lines into one request toward a processor core. Each line has a bit in an enable (mask) register and a bit in a pending (status) register. Both registers are reached through a small register port that selects one of the two. Software reads them, changes them and writes them back. The request output is high whenever an enabled line has its pending bit set.

A build-time parameter selects how the pending bits behave, in one of three ways:
- **Level:** each pending bit follows its synchronised input, and nothing is stored.
- **Edge:** a rising edge sets the pending bit, and the bit stays set until software writes a 1 to it.
- **Legacy latch:** the input level is latched, and software clears a bit by writing 0 to it.

Software reads every pending line at once and services them from the lowest index upward until none remain. Vectoring and priority logic are not part of this block.

Top module: `irq_hub`

## Requirements
- R1: After a synchronous active-low reset, the mask register reads 0, the status register reads 0 and `irq_req` is 0.
- R2: A write with `reg_sel`=0 stores `reg_wdata` in the mask register. With `reg_sel`=0, `reg_rdata` returns the mask register. Mask bit n = 1 enables line n.
- R3: `irq_req` is registered. It equals the OR over all bits of (status AND mask) as sampled on the previous rising clock edge.
- R4: In edge mode, a rising edge on line n sets status bit n. The bit stays set after the line falls.
- R5: In edge mode, a status write (`reg_sel`=1) clears every bit written as 1. Bits written as 0 keep their value.
- R6: In level mode, each status bit equals the synchronised input. Status writes have no effect.
- R7: In legacy mode, a high input sets its status bit, and the bit stays set after the input falls. A status write clears every bit written as 0 and leaves every bit written as 1 unchanged.
- R8: When a new event and a clear hit the same status bit on the same clock edge, the bit stays set. This covers a new rising edge in edge mode and a still-high input in legacy mode.
- R9: Status bits latch while their line is masked. Unmasking a pending line raises `irq_req` one edge after the mask write takes effect. With mask 0, `irq_req` stays 0.
- R10: Inputs pass through a two-flop synchroniser. A change on `irq_in` at the input is visible in status after two rising edges in level mode and after three rising edges in edge and legacy modes.
- R11: The status register reports all pending lines at once. Clearing the lowest pending bit leaves the higher ones pending, so servicing from the lowest index upward empties the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 32 | Asynchronous interrupt lines, bit n = line n |
| reg_sel | input | 1 | Register select: 0 = mask, 1 = status |
| reg_we | input | 1 | Write enable for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data of the selected register |
| irq_req | output | 1 | Registered interrupt request to the core |

## Verification
A corrupted pending bit shows up on `reg_rdata` as soon as the status register is selected. It also shows up on `irq_req` one edge later if that line is enabled. A lost or stuck latch therefore shows within one read, or within a single cycle at the request pin. An off-by-one in the synchroniser or in the edge detector moves the first cycle in which the status bit appears, so the bench samples the status register on each edge after an input change. A wrong clear polarity leaves a bit set, or clears a neighbour, on the very next read after the write.

// File: rtl/irq_hub_pkg.sv
// Shared definitions for the interrupt collector.
// Assumes: included first in compile order.
package irq_hub_pkg;
    // Selects how pending bits are set and cleared.
    typedef enum logic [1:0] {
        STAT_LEVEL     = 2'd0,
        STAT_EDGE      = 2'd1,
        STAT_LATCH_W0C = 2'd2
    } stat_mode_e;
endpackage

// File: rtl/irq_hub_sync.sv
// Multi-stage synchroniser for a vector of asynchronous lines.
// Assumes: each line is independent; no bus coherency is needed.
module irq_hub_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] chain [STAGES];

    // Shift the inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= async_in;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign sync_out = chain[LAST];
endmodule

// File: rtl/irq_hub_status.sv
// Pending register with build-time selectable set/clear behaviour.
// Assumes: line_in is already synchronised; clr_en marks a status write.
module irq_hub_status #(
    parameter int                     WIDTH = 32,
    parameter irq_hub_pkg::stat_mode_e MODE  = irq_hub_pkg::STAT_EDGE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] line_in,
    input  logic             clr_en,
    input  logic [WIDTH-1:0] wr_bits,
    output logic [WIDTH-1:0] status
);
    generate
        if (MODE == irq_hub_pkg::STAT_EDGE) begin : g_edge
            logic [WIDTH-1:0] prev_q;
            logic [WIDTH-1:0] rise;
            logic [WIDTH-1:0] status_q;

            assign rise = line_in & ~prev_q;

            // Remember the last synchronised sample for edge detection.
            always_ff @(posedge clk) begin
                if (!rst_n) prev_q <= '0;
                else        prev_q <= line_in;
            end

            // Clear written ones, then let new edges set (event wins).
            always_ff @(posedge clk) begin
                if (!rst_n) status_q <= '0;
                else        status_q <= (status_q & ~(clr_en ? wr_bits : '0)) | rise;
            end

            assign status = status_q;

            assert_edge_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (|rise) |=> ((status_q & $past(rise)) == $past(rise)));
            assert_w1c_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_en && ((wr_bits & ~rise) != '0)) |=> ((status_q & $past(wr_bits & ~rise)) == '0));
        end else if (MODE == irq_hub_pkg::STAT_LATCH_W0C) begin : g_latch
            logic [WIDTH-1:0] status_q;

            // Clear bits written as zero, then re-latch any high input.
            always_ff @(posedge clk) begin
                if (!rst_n) status_q <= '0;
                else        status_q <= (clr_en ? (status_q & wr_bits) : status_q) | line_in;
            end

            assign status = status_q;

            assert_latch_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
                !clr_en |=> ((status_q & $past(status_q)) == $past(status_q)));
            assert_input_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (|line_in) |=> ((status_q & $past(line_in)) == $past(line_in)));
        end else begin : g_level
            logic unused_wr;
            assign unused_wr = ^{clr_en, wr_bits, clk, rst_n};
            assign status    = line_in;
        end
    endgenerate
endmodule

// File: rtl/irq_hub_req.sv
// Registered OR-reduction of enabled pending bits into one request.
// Assumes: a one-cycle delay of the request is acceptable to the core.
module irq_hub_req #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pend_i,
    input  logic [WIDTH-1:0] en_i,
    output logic             req_o
);
    // Register the request so the core sees a glitch-free level.
    always_ff @(posedge clk) begin
        if (!rst_n) req_o <= 1'b0;
        else        req_o <= |(pend_i & en_i);
    end

    assert_req_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_i & en_i) == '0) |=> !req_o);
endmodule

// File: rtl/irq_hub.sv
// Interrupt collector top: synchroniser, mask register, pending register
// and request generation behind a two-register read/write port.
// Assumes: reg_sel/reg_we/reg_wdata are synchronous to clk.
module irq_hub #(
    parameter int                     N_LINES = 32,
    parameter int                     SYNC_FF = 2,
    parameter irq_hub_pkg::stat_mode_e MODE    = irq_hub_pkg::STAT_EDGE
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_in,
    input  logic               reg_sel,
    input  logic               reg_we,
    input  logic [N_LINES-1:0] reg_wdata,
    output logic [N_LINES-1:0] reg_rdata,
    output logic               irq_req
);
    localparam logic SEL_MASK = 1'b0;
    localparam logic SEL_STAT = 1'b1;

    logic [N_LINES-1:0] line_sync;
    logic [N_LINES-1:0] mask_q;
    logic [N_LINES-1:0] stat;
    logic               stat_wr;

    irq_hub_sync #(.WIDTH(N_LINES), .STAGES(SYNC_FF)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (irq_in),
        .sync_out (line_sync)
    );

    assign stat_wr = reg_we && (reg_sel == SEL_STAT);

    irq_hub_status #(.WIDTH(N_LINES), .MODE(MODE)) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (line_sync),
        .clr_en  (stat_wr),
        .wr_bits (reg_wdata),
        .status  (stat)
    );

    // Plain read/write enable register; all lines disabled at reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                                mask_q <= '0;
        else if (reg_we && (reg_sel == SEL_MASK))  mask_q <= reg_wdata;
    end

    // Return the selected register.
    always_comb begin
        reg_rdata = (reg_sel == SEL_STAT) ? stat : mask_q;
    end

    irq_hub_req #(.WIDTH(N_LINES)) u_req (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_i (stat),
        .en_i   (mask_q),
        .req_o  (irq_req)
    );

    assert_mask_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel == SEL_MASK) |=> (mask_q == $past(reg_wdata)));
    assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |=> !irq_req);
endmodule

// File: tb/irq_hub_test.sv
`timescale 1ns/100ps
module irq_hub_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic        reg_sel = 1'b0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] rd_e, rd_v, rd_g;
    logic        rq_e, rq_v, rq_g;
    int          n_chk = 0;
    int          n_bad = 0;

    always #2.5 clk = ~clk;

    irq_hub #(.MODE(irq_hub_pkg::STAT_EDGE)) uut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_sel(reg_sel),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(rd_e), .irq_req(rq_e));
    irq_hub #(.MODE(irq_hub_pkg::STAT_LEVEL)) uut_level (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_sel(reg_sel),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(rd_v), .irq_req(rq_v));
    irq_hub #(.MODE(irq_hub_pkg::STAT_LATCH_W0C)) uut_legacy (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_sel(reg_sel),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(rd_g), .irq_req(rq_g));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic s, input logic [31:0] d);
        reg_sel = s; reg_wdata = d; reg_we = 1'b1;
        tick(1);
        reg_we = 1'b0;
    endtask

    task automatic sel(input logic s);
        reg_sel = s;
        #1;
    endtask

    task automatic t_reset;
        sel(1'b1);
        chk("R1 edge status", rd_e, 0); chk("R1 level status", rd_v, 0); chk("R1 legacy status", rd_g, 0);
        sel(1'b0);
        chk("R1 mask", rd_e, 0);
        chk("R1 req", {29'd0, rq_e, rq_v, rq_g}, 0);
    endtask

    task automatic t_mask_rw;
        wr(1'b0, 32'hA5A5_0F0F);
        sel(1'b0);
        chk("R2 mask readback", rd_e, 32'hA5A5_0F0F);
        chk("R2 mask readback legacy", rd_g, 32'hA5A5_0F0F);
        wr(1'b0, 32'h0);
        sel(1'b0);
        chk("R2 mask cleared", rd_e, 0);
    endtask

    task automatic t_latency_edge;
        sel(1'b1);
        irq_in = 32'h8;
        tick(1);
        chk("R10 edge after 1 edge", rd_e, 0);
        tick(1);
        chk("R10 level after 2 edges", rd_v, 32'h8);
        chk("R10 edge after 2 edges", rd_e, 0);
        tick(1);
        chk("R10 edge after 3 edges", rd_e, 32'h8);
        chk("R10 legacy after 3 edges", rd_g, 32'h8);
        irq_in = 32'h0;
        tick(4);
        chk("R4 edge held after fall", rd_e, 32'h8);
        chk("R7 legacy held after fall", rd_g, 32'h8);
        chk("R6 level follows fall", rd_v, 0);
        chk("R9 masked no req", {30'd0, rq_e, rq_g}, 0);
    endtask

    task automatic t_unmask;
        wr(1'b0, 32'hFFFF_FFFF);
        chk("R3 req not yet", {30'd0, rq_e, rq_g}, 0);
        tick(1);
        chk("R9 edge req after unmask", {31'd0, rq_e}, 1);
        chk("R9 legacy req after unmask", {31'd0, rq_g}, 1);
        chk("R6 level no req", {31'd0, rq_v}, 0);
    endtask

    task automatic t_edge_clear;
        wr(1'b1, 32'h4);
        sel(1'b1);
        chk("R5 edge zero write keeps", rd_e, 32'h8);
        chk("R7 legacy zero write clears", rd_g, 0);
        wr(1'b1, 32'h8);
        sel(1'b1);
        chk("R5 edge one write clears", rd_e, 0);
        chk("R7 legacy stays clear", rd_g, 0);
        tick(1);
        chk("R3 edge req drops", {31'd0, rq_e}, 0);
    endtask

    task automatic t_legacy;
        irq_in = 32'h30;
        tick(3);
        sel(1'b1);
        chk("R6 level shows input", rd_v, 32'h30);
        wr(1'b1, 32'hFFFF_FFFF);
        sel(1'b1);
        chk("R7 legacy one write no effect", rd_g, 32'h30);
        chk("R6 level write no effect", rd_v, 32'h30);
        wr(1'b1, 32'hFFFF_FFEF);
        sel(1'b1);
        chk("R8 legacy high input wins", rd_g, 32'h30);
        irq_in = 32'h0;
        tick(3);
        wr(1'b1, ~32'h10);
        sel(1'b1);
        chk("R7 legacy clears only zero bit", rd_g, 32'h20);
        chk("R6 level low", rd_v, 0);
        wr(1'b1, 32'h0);
    endtask

    task automatic t_event_wins;
        irq_in = 32'h40;
        tick(3);
        irq_in = 32'h0;
        tick(3);
        sel(1'b1);
        chk("R4 edge bit6 set", rd_e, 32'h40);
        irq_in = 32'h40;
        tick(2);
        wr(1'b1, 32'h40);
        sel(1'b1);
        chk("R8 edge event beats clear", rd_e, 32'h40);
        irq_in = 32'h0;
        tick(2);
        wr(1'b1, 32'h40);
        sel(1'b1);
        chk("R5 edge cleared afterwards", rd_e, 0);
    endtask

    task automatic t_multi;
        logic [31:0] exp;
        irq_in = 32'h8100_0201;
        tick(3);
        irq_in = 32'h0;
        tick(3);
        exp = 32'h8100_0201;
        sel(1'b1);
        chk("R11 all pending at once", rd_e, exp);
        for (int k = 0; k < 4; k++) begin
            logic [31:0] low;
            low = exp & (~exp + 32'd1);
            wr(1'b1, low);
            exp = exp & ~low;
            sel(1'b1);
            chk("R11 lowest cleared, rest kept", rd_e, exp);
        end
        tick(1);
        chk("R11 req idle when empty", {31'd0, rq_e}, 0);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_mask_rw();
        t_latency_edge();
        t_unmask();
        t_edge_clear();
        t_legacy();
        t_event_wins();
        t_multi();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule